// File: doc/BRIEF.md
# Memory-Mapped Signed Multiplier Slave

This block is a peripheral on a simple address/data bus. It keeps two signed 16-bit operand registers and hands out their full signed product through a third address. A master performs one multiply with three transfers: it writes the first operand, writes the second operand and then reads the product.

The product is not ready when the read arrives. A read of the product address pulls `ready` low for a fixed number of cycles while the product is formed. During that time the master must keep the read request asserted. The transfer completes in the first cycle in which `ready` is high again, and in that cycle `rdata` carries the product. Only one product is in flight at a time, and every product read pays the full stall.

Top module: `mul_slave`

## Requirements
- R1: After reset both operand registers read back as zero, `ready` is high while the bus is idle, and a read of the unused address 3 returns zero.
- R2: A write to address 0 with `ready` high stores `wdata` as operand A. A later read of address 0 returns it sign-extended to 32 bits, without a stall.
- R3: A write to address 1 with `ready` high stores `wdata` as operand B. A later read of address 1 returns it sign-extended to 32 bits, without a stall.
- R4: A read of address 2 drives `ready` low in the cycle the request is first presented. `ready` stays low for exactly LAT (default 10) consecutive cycles.
- R5: In the cycle `ready` returns high during a held address-2 read, `rdata` equals the 32-bit two's-complement product of the stored operands. This holds at the extremes, for example -32768 × -32768 = 0x40000000.
- R6: Each address-2 read is a new computation with its own full LAT-cycle stall, even when the operands are unchanged.
- R7: A write presented while `ready` is low is not accepted. The operand registers keep their values.
- R8: Addresses other than 0, 1 and 2 ignore writes, return zero on reads and never lower `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address (AW) |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wdata | input | 16 | Write data (OPW) |
| rdata | output | 32 | Read data (2·OPW) |
| ready | output | 1 | High when the current transfer completes this cycle |

## Verification
The bench counts the low cycles of `ready` on every product read. A counter that is off by one, or a stall that begins only after a register delay, shows up as a count of 9 or 11 instead of 10. Products at the signed extremes and with mixed signs expose a design that multiplies unsigned or truncates the result. Back-to-back product reads catch a design that returns a cached value without stalling. A write issued during a stall, followed by operand readback, catches operands that change while a product is in flight. Reads and writes at unused addresses catch decode aliasing and stray stalls.

// File: rtl/mul_slave.sv
module mul_slave #(
  parameter int OPW = 16,
  parameter int AW  = 4,
  parameter int LAT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [OPW-1:0]     wdata,
  output logic [2*OPW-1:0]   rdata,
  output logic               ready
);
  localparam int RW = 2 * OPW;
  localparam int CW = $clog2(LAT + 1);
  localparam logic [AW-1:0] A_ADR = AW'(0);
  localparam logic [AW-1:0] B_ADR = AW'(1);
  localparam logic [AW-1:0] R_ADR = AW'(2);

  logic signed [OPW-1:0] opa, opb;
  logic signed [RW-1:0]  res;
  logic                  busy, hold;
  logic [CW-1:0]         left;

  wire sel_a  = addr == A_ADR;
  wire sel_b  = addr == B_ADR;
  wire rd_res = rd_en & (addr == R_ADR);
  wire start  = rd_res & ~busy & ~hold;

  assign ready = ~busy & ~(rd_res & ~hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa  <= '0;
      opb  <= '0;
      res  <= '0;
      busy <= 1'b0;
      hold <= 1'b0;
      left <= '0;
    end else begin
      hold <= 1'b0;
      if (wr_en && ready && sel_a) opa <= wdata;
      if (wr_en && ready && sel_b) opb <= wdata;
      if (start) begin
        busy <= 1'b1;
        left <= CW'(LAT - 1);
      end else if (busy) begin
        if (left == CW'(1)) begin
          busy <= 1'b0;
          hold <= 1'b1;
          res  <= opa * opb;
        end else begin
          left <= left - CW'(1);
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel_a)             rdata = {{OPW{opa[OPW-1]}}, opa};
      else if (sel_b)        rdata = {{OPW{opb[OPW-1]}}, opb};
      else if (rd_res && hold) rdata = res;
    end
  end
endmodule

// File: rtl/mul_slave_chk.sv
module mul_slave_chk #(
  parameter int OPW = 16,
  parameter int AW  = 4,
  parameter int LAT = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [AW-1:0]         addr,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [OPW-1:0]        wdata,
  input logic [2*OPW-1:0]      rdata,
  input logic                  ready,
  input logic signed [OPW-1:0] opa,
  input logic signed [OPW-1:0] opb
);
  localparam int RW = 2 * OPW;
  localparam int CW = $clog2(LAT + 2);

  logic signed [OPW-1:0] sa, sb;
  logic signed [RW-1:0]  prod;
  logic [CW-1:0]         lowrun;

  assign prod = sa * sb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
      lowrun <= '0;
    end else begin
      if (wr_en && ready && addr == AW'(0)) sa <= wdata;
      if (wr_en && ready && addr == AW'(1)) sb <= wdata;
      if (!ready) lowrun <= lowrun + CW'(1);
      else        lowrun <= '0;
    end
  end

  p_stall_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && lowrun != '0) |-> lowrun == CW'(LAT));

  p_stall_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun <= CW'(LAT));

  p_product_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(2) && ready) |-> rdata == prod);

  p_no_write_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready) |=> (opa == $past(opa) && opb == $past(opb)));

  p_unused_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr > AW'(2)) |-> (ready && rdata == '0));
endmodule

bind mul_slave mul_slave_chk #(.OPW(OPW), .AW(AW), .LAT(LAT)) u_chk (.*);

// File: tb/tb_mul_slave.sv
module tb_mul_slave;
  localparam int LAT = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  mul_slave dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                 .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .ready(ready));

  always #2 clk = ~clk;

  function automatic logic [31:0] exp_prod(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] sa, sb;
    sa = {{16{a[15]}}, a};
    sb = {{16{b[15]}}, b};
    return sa * sb;
  endfunction

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_plain(input logic [3:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    check(ready === 1'b1, req, {31'b0, ready}, 32'd1);
    check(rdata === exp, req, rdata, exp);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_prod(input logic [15:0] a, input logic [15:0] b, input string req);
    int low;
    low = 0;
    @(negedge clk);
    addr = 4'd2; rd_en = 1'b1;
    #1;
    while (ready !== 1'b1 && low < 40) begin
      low++;
      @(negedge clk);
      #1;
    end
    check(low == LAT, "R4 stall length", low, LAT);
    check(rdata === exp_prod(a, b), req, rdata, exp_prod(a, b));
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic mul(input logic [15:0] a, input logic [15:0] b, input string req);
    wr(4'd0, a);
    wr(4'd1, b);
    rd_prod(a, b, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    check(ready === 1'b1, "R1 ready after reset", {31'b0, ready}, 32'd1);
    rst_n = 1'b1;
    rd_plain(4'd0, "R1 opa reset", 32'd0);
    rd_plain(4'd1, "R1 opb reset", 32'd0);
    rd_plain(4'd3, "R1 unused read", 32'd0);

    wr(4'd0, 16'd3);
    rd_plain(4'd0, "R2 opa readback", 32'd3);
    wr(4'd1, 16'hFFFB);
    rd_plain(4'd1, "R3 opb readback", 32'hFFFF_FFFB);
    rd_prod(16'd3, 16'hFFFB, "R5 3*-5");

    mul(16'h8000, 16'h8000, "R5 min*min");
    mul(16'h7FFF, 16'h8000, "R5 max*min");
    mul(16'h7FFF, 16'h7FFF, "R5 max*max");
    mul(16'h0000, 16'h1234, "R5 zero");
    mul(16'hFFFF, 16'hFFFF, "R5 -1*-1");

    rd_prod(16'hFFFF, 16'hFFFF, "R6 repeat read 1");
    rd_prod(16'hFFFF, 16'hFFFF, "R6 repeat read 2");

    wr(4'd0, 16'd7);
    wr(4'd1, 16'd9);
    @(negedge clk);
    addr = 4'd2; rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0; addr = 4'd0; wdata = 16'h5555; wr_en = 1'b1;
    #1;
    check(ready === 1'b0, "R7 ready low mid stall", {31'b0, ready}, 32'd0);
    repeat (2) @(negedge clk);
    addr = 4'd1; wdata = 16'h6666;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    rd_plain(4'd0, "R7 opa kept", 32'd7);
    rd_plain(4'd1, "R7 opb kept", 32'd9);
    rd_prod(16'd7, 16'd9, "R7 product of kept operands");

    wr(4'd3, 16'hAAAA);
    wr(4'd15, 16'hBBBB);
    rd_plain(4'd0, "R8 opa untouched", 32'd7);
    rd_plain(4'd1, "R8 opb untouched", 32'd9);
    rd_plain(4'd3, "R8 read addr 3", 32'd0);
    rd_plain(4'd15, "R8 read addr 15", 32'd0);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom());
      rb = 16'($urandom());
      wr(4'd0, ra);
      wr(4'd1, rb);
      rd_plain(4'd0, "R2 random readback", sext(ra));
      rd_plain(4'd1, "R3 random readback", sext(rb));
      rd_prod(ra, rb, "R5 random product");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule